// File: doc/BRIEF.md
# Page-Buffered Write Engine for a Serial EEPROM

This block sits behind the serial bus slave of a two-wire EEPROM. Once a write header has been decoded, the slave passes on the starting word address. After that it signals every received data byte, every START and every STOP. The block stores the bytes in a 16-byte page latch. The low four bits of the word address choose the column and the remaining bits choose the row. The column pointer advances after each byte and wraps inside the row, so bytes beyond the sixteenth overwrite earlier columns.

Nothing is programmed until STOP arrives. At STOP, the block walks the sixteen columns in ascending order and writes only the columns that received a byte. It then holds a busy flag for a self-timed write interval, given in system clock cycles, and marks the end with a one-cycle done pulse. A START before the STOP discards the load. So do an active write-protect input at STOP and a header with no data. While busy, the block ignores all bus-side inputs.

Top module: `eeprom_page_writer`

## Requirements
- R1: During and right after reset, `busy`, `mem_we` and `done` are low.
- R2: A header sets the row to `hdr_addr[ADDR_W-1:4]` and the column to `hdr_addr[3:0]`. Each accepted byte goes to the current column, after which the column increments by one. The row stays the same for the whole load.
- R3: The column wraps from 15 to 0 within the same row. A byte loaded past the sixteenth replaces the byte held in that column, and only the last value is committed.
- R4: During the commit, exactly the loaded columns are written. They are written one per cycle in ascending column order, with `mem_addr = {row, column}` and `mem_wdata` equal to the stored byte. `mem_we` is only high while `busy` is high.
- R5: Programming starts only at STOP. `busy` is low while bytes load and is high in the cycle after the STOP is sampled.
- R6: `busy` stays high for exactly 16 + `WRITE_CYCLES` cycles. `done` pulses once, for one cycle, in the last busy cycle.
- R7: If `wp` is high when STOP is sampled, no write strobe occurs and `busy` stays low.
- R8: A START after the header and before the STOP discards the load. No write occurs, no busy appears, and a later STOP has no effect.
- R9: A header followed by STOP with no data bytes produces no write, no busy and no done.
- R10: While `busy` is high, headers, bytes, START and STOP are ignored. The commit in progress is unchanged, and no further write or busy period follows it.
- R11: A new header clears the record of loaded columns. Bytes from an earlier, aborted load are never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Write header decoded; `hdr_addr` is valid |
| hdr_addr | input | ADDR_W | Starting word address (row in upper bits, column in low 4 bits) |
| byte_valid | input | 1 | One received data byte on `byte_data` |
| byte_data | input | 8 | Data byte |
| start_seen | input | 1 | START or repeated START observed on the bus |
| stop_seen | input | 1 | STOP observed on the bus |
| wp | input | 1 | Write protect, high blocks programming |
| busy | output | 1 | Commit or self-timed write in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array word address for the strobe |
| mem_wdata | output | 8 | Array write data |
| done | output | 1 | One-cycle pulse ending the busy period |

## Verification
The main function is exercised in several ways. A single byte checks the basic address mapping. A three-byte partial page that starts at column 14 shows that wrapped columns stay in the same row and are committed in column order, not arrival order. An eighteen-byte overflow checks that the overwritten columns hold the later values. Further runs cover a write-protected STOP, a START abort, an empty header, and an abort followed by a fresh one-byte header, which shows the loaded-column record is cleared. A final run injects bus activity in the middle of a busy period to show it has no effect on the strobes or on the busy length.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;

    localparam int BYTE_W     = 8;
    localparam int PAGE_BYTES = 16;
    localparam int COL_W      = $clog2(PAGE_BYTES);

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_LOAD,
        PG_COMMIT,
        PG_WAIT
    } pg_state_e;

    typedef struct packed {
        logic  en;
        col_t  col;
        byte_t data;
    } col_wr_s;

    function automatic col_t col_step(input col_t c);
        return c + 1'b1;
    endfunction

endpackage

// File: rtl/page_latch.sv
module page_latch
    import eeprom_page_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  col_wr_s               wr,
    input  col_t                  rd_col,
    output byte_t                 rd_data,
    output logic [PAGE_BYTES-1:0] mask_o
);

    byte_t                 cell_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q[gi] <= '0;
            end else if (wr.en && wr.col == col_t'(gi)) begin
                cell_q[gi] <= wr.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mask_q <= '0;
        end else if (wr.en) begin
            mask_q[wr.col] <= 1'b1;
        end
    end

    assign rd_data = cell_q[rd_col];
    assign mask_o  = mask_q;

    AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> mask_o == '0); // R11

    AST_MASK_MARKS: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !clr) |=> mask_o[$past(wr.col)]); // R4

endmodule

// File: rtl/write_timer.sv
module write_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic zero_o
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !load) |=> (cnt_q + 1'b1) == $past(cnt_q)); // R6

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_page_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int WRITE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              wp,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              done
);

    localparam int ROW_W = ADDR_W - COL_W;

    pg_state_e             state_q, state_d;
    logic [ROW_W-1:0]      row_q;
    col_t                  col_q;
    col_t                  scan_q;
    logic [PAGE_BYTES-1:0] mask;
    byte_t                 rd_data;
    col_wr_s               wr;
    logic                  accept_hdr;
    logic                  tmr_load;
    logic                  tmr_zero;

    assign accept_hdr = hdr_valid && (state_q == PG_IDLE || state_q == PG_LOAD);

    always_comb begin
        wr.en   = (state_q == PG_LOAD) && byte_valid && !hdr_valid
                  && !start_seen && !stop_seen;
        wr.col  = col_q;
        wr.data = byte_data;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE: if (accept_hdr) state_d = PG_LOAD;
            PG_LOAD: begin
                if (hdr_valid)       state_d = PG_LOAD;
                else if (start_seen) state_d = PG_IDLE;
                else if (stop_seen)  state_d = (mask != '0 && !wp) ? PG_COMMIT : PG_IDLE;
            end
            PG_COMMIT: if (scan_q == col_t'(PAGE_BYTES - 1)) state_d = PG_WAIT;
            PG_WAIT:   if (tmr_zero) state_d = PG_IDLE;
            default:   state_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PG_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            scan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept_hdr) begin
                row_q <= hdr_addr[ADDR_W-1:COL_W];
                col_q <= hdr_addr[COL_W-1:0];
            end else if (wr.en) begin
                col_q <= col_step(col_q);
            end
            if (state_q == PG_COMMIT) scan_q <= col_step(scan_q);
            else                      scan_q <= '0;
        end
    end

    assign tmr_load = (state_q == PG_COMMIT) && (scan_q == col_t'(PAGE_BYTES - 1));

    page_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept_hdr),
        .wr      (wr),
        .rd_col  (scan_q),
        .rd_data (rd_data),
        .mask_o  (mask)
    );

    write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .zero_o (tmr_zero)
    );

    assign busy      = (state_q == PG_COMMIT) || (state_q == PG_WAIT);
    assign mem_we    = (state_q == PG_COMMIT) && mask[scan_q];
    assign mem_addr  = {row_q, scan_q};
    assign mem_wdata = rd_data;
    assign done      = (state_q == PG_WAIT) && tmr_zero;

    AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy); // R4

    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R6

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R6

    AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (state_q == PG_LOAD && stop_seen && !hdr_valid && !start_seen && wp) |=> !busy); // R7

    AST_ABORT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (state_q == PG_LOAD && start_seen && !hdr_valid) |=> !busy); // R8

    AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(row_q)); // R10

endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int WC         = 20;
    localparam int BUSY_LEN   = 16 + WC;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hdr_valid = 1'b0;
    logic [ADDR_W-1:0] hdr_addr = '0;
    logic              byte_valid = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              start_seen = 1'b0;
    logic              stop_seen = 1'b0;
    logic              wp = 1'b0;
    logic              busy, mem_we, done;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;

    eeprom_page_writer #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WC)) i_eeprom_page_writer (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_addr(hdr_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .start_seen(start_seen),
        .stop_seen(stop_seen), .wp(wp), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int busy_cycles = 0;
    int done_pulses = 0;
    int exp_busy = 0;
    int exp_done = 0;
    int exp_q[$];

    logic [7:0]        m_dat [16];
    logic [15:0]       m_mask = '0;
    logic [ADDR_W-5:0] m_row = '0;
    logic [3:0]        m_col = '0;
    bit                m_open = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected strobes as the design produces them
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cycles++;
            if (done) done_pulses++;
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4", "unexpected write", int'({mem_addr, mem_wdata}), 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'({mem_addr, mem_wdata}) == e, "R4", "write addr/data",
                          int'({mem_addr, mem_wdata}), e);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_hdr(input logic [ADDR_W-1:0] a, input bit model);
        hdr_valid = 1'b1; hdr_addr = a;
        tick();
        hdr_valid = 1'b0;
        if (model) begin
            m_mask = '0; m_row = a[ADDR_W-1:4]; m_col = a[3:0]; m_open = 1;
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input bit model);
        byte_valid = 1'b1; byte_data = d;
        tick();
        byte_valid = 1'b0;
        if (model && m_open) begin
            m_dat[m_col] = d; m_mask[m_col] = 1'b1; m_col = m_col + 1'b1;
        end
    endtask

    task automatic send_start(input bit model);
        start_seen = 1'b1;
        tick();
        start_seen = 1'b0;
        if (model) m_open = 0;
    endtask

    task automatic send_stop(input bit model);
        stop_seen = 1'b1;
        tick();
        stop_seen = 1'b0;
        if (model) begin
            if (m_open && !wp && m_mask != '0) begin
                for (int c = 0; c < 16; c++)
                    if (m_mask[c]) exp_q.push_back(int'({m_row, 4'(c), m_dat[c]}));
                exp_busy = BUSY_LEN; exp_done = 1;
            end
            m_open = 0;
        end
    endtask

    task automatic begin_scn();
        busy_cycles = 0; done_pulses = 0; exp_busy = 0; exp_done = 0;
    endtask

    task automatic end_scn(input string req);
        repeat (BUSY_LEN + 6) tick();
        check(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
        check(busy_cycles == exp_busy, req, "busy length", busy_cycles, exp_busy);
        check(done_pulses == exp_done, req, "done pulses", done_pulses, exp_done);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL R6 watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        check({busy, mem_we, done} == 3'b000, "R1", "outputs in reset",
              int'({busy, mem_we, done}), 0);
        rst = 1'b0;
        tick();
        check({busy, mem_we, done} == 3'b000, "R1", "outputs after reset",
              int'({busy, mem_we, done}), 0);

        // R2 R5 R6: single byte
        begin_scn();
        send_hdr(10'h123, 1);
        send_byte(8'hA5, 1);
        check(busy == 1'b0, "R5", "busy before stop", busy, 0);
        send_stop(1);
        check(busy == 1'b1, "R5", "busy after stop", busy, 1);
        end_scn("R6");

        // R3 R2: partial page wrapping in the row
        begin_scn();
        send_hdr(10'h3AE, 1);
        send_byte(8'h11, 1); send_byte(8'h22, 1); send_byte(8'h33, 1);
        send_stop(1);
        end_scn("R3");

        // R3: 18 bytes overwrite two columns
        begin_scn();
        send_hdr(10'h205, 1);
        for (int i = 0; i < 18; i++) send_byte(8'(8'h40 + i), 1);
        send_stop(1);
        end_scn("R3");

        // R7: write protect
        begin_scn();
        send_hdr(10'h0F0, 1);
        send_byte(8'h5A, 1); send_byte(8'hC3, 1);
        wp = 1'b1;
        send_stop(1);
        wp = 1'b0;
        end_scn("R7");

        // R8: START abort, stray STOP later
        begin_scn();
        send_hdr(10'h044, 1);
        send_byte(8'h99, 1);
        send_start(1);
        send_stop(1);
        end_scn("R8");

        // R9: empty header
        begin_scn();
        send_hdr(10'h177, 1);
        send_stop(1);
        end_scn("R9");

        // R11: aborted load then fresh one-byte header
        begin_scn();
        send_hdr(10'h260, 1);
        send_byte(8'hE1, 1); send_byte(8'hE2, 1);
        send_start(1);
        send_hdr(10'h268, 1);
        send_byte(8'h7E, 1);
        send_stop(1);
        end_scn("R11");

        // R10: bus activity during busy is ignored
        begin_scn();
        send_hdr(10'h301, 1);
        send_byte(8'hB0, 1); send_byte(8'hB1, 1);
        send_stop(1);
        repeat (2) tick();
        send_hdr(10'h3F0, 0);
        send_byte(8'hDD, 0); send_byte(8'hEE, 0);
        send_stop(0);
        send_start(0);
        end_scn("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule